// File: doc/BRIEF.md
# Programmable shift pattern generator

The block serialises a bit pattern of 1 to 64 bits onto a single output pin. Software puts the pattern into two 32-bit data words, picks a pass length, a shift direction and either a single-pass or a looping behaviour, then sets the run bit. A period divider derives a bit tick from the system clock, and every tick moves the working register by one position.

At every pass boundary the working register either reloads from the data words and carries on without a gap (looping) or stops and drops its own run bit (single pass). A fill flag marks each load, so software knows the data words may be rewritten. A done flag marks each finished pass. Both flags are cleared by writing ones, and each has its own interrupt enable.

Top module: `shift_pattern_gen`

## Requirements
- R1: After reset, pat_o, run_o, irq_o and flags_o are all 0.
- R2: Write port map, one write per cycle with wr_en_i:
  - address 0: run bit, data bit 0.
  - address 1: mode. Bit 0 selects looping (1) or single pass (0). Bit 1 selects left shift (1) or right shift (0).
  - address 2: pass length, 1 to 64.
  - address 3: period P.
  - address 4: low data word, pattern bits 31:0.
  - address 5: high data word, pattern bits 63:32.
  - address 6: flag clear, write-one-to-clear.
  - address 7: interrupt enables.
  - Flag bit 0 is fill and flag bit 1 is done. flags_o and the interrupt enable register use the same bit positions.
- R3: Each pattern bit stays on pat_o for exactly P+1 cycles. The first bit appears in the cycle after the write that sets the run bit.
- R4: In right-shift mode, pattern bit 0 goes out first and bit length−1 goes out last.
- R5: In left-shift mode, pattern bit length−1 goes out first and bit 0 goes out last.
- R6: In single-pass mode, after length bits the block clears run_o, drives pat_o to 0 and sets the done flag.
- R7: In looping mode, every pass boundary sets the done flag, keeps run_o at 1 and starts the next pass with no idle cycle. That next pass uses data words written during the previous pass.
- R8: Every load of the working register sets the fill flag: the start of a run and each looping reload.
- R9: Writes to mode and length are ignored while run_o is 1.
- R10: Flags are write-one-to-clear. irq_o is 1 exactly when some flag is set together with its interrupt enable bit.
- R11: Writing 0 to the run bit stops shifting, and pat_o and run_o read 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 32 | Register write data |
| pat_o | output | 1 | Serial pattern output |
| run_o | output | 1 | Run bit |
| flags_o | output | 2 | Fill (bit 0) and done (bit 1) flags |
| irq_o | output | 1 | Interrupt request |

## Verification
Let E be the clock edge that samples the run-bit write. Pattern bit k is due from edge E + k·(P+1), and the pass boundary, with its flags and reload, lands on edge E + length·(P+1). The checks count negative edges from E and sample every output on the negedge that follows the edge they are due at, so that each sample sits half a period away from any active edge. Register writes take effect on the edge that samples them, so control and flag results are read one negedge after the write.

// File: rtl/spg_pkg.sv
package spg_pkg;
  typedef enum logic [2:0] {
    A_RUN    = 3'd0,
    A_MODE   = 3'd1,
    A_LEN    = 3'd2,
    A_PERIOD = 3'd3,
    A_DATA0  = 3'd4,
    A_DATA1  = 3'd5,
    A_FLAGS  = 3'd6,
    A_IRQEN  = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic left;
    logic rpt;
  } mode_t;

  localparam int FLAG_FILL = 0;
  localparam int FLAG_DONE = 1;
  localparam int NFLAGS    = 2;
endpackage

// File: rtl/spg_tick.sv
module spg_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic [DIV_W-1:0] period_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!en_i || start_i)   cnt_q <= '0;
    else if (cnt_q == period_i)  cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  // R3: with a non-zero, unchanged period, ticks never come back to back
  assert_tick_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && period_i != '0) |=> (!tick_o || period_i != $past(period_i)));
endmodule

// File: rtl/spg_regs.sv
module spg_regs
  import spg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PAT_W  = 64,
  parameter int DIV_W  = 16,
  parameter int LEN_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              fill_set_i,
  input  logic              done_set_i,
  input  logic              stop_i,
  output logic              en_o,
  output logic              start_o,
  output mode_t             mode_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [DIV_W-1:0]  period_o,
  output logic [PAT_W-1:0]  data_o,
  output logic [NFLAGS-1:0] flags_o,
  output logic              irq_o
);
  localparam int NWORDS = PAT_W / DATA_W;

  logic              en_q;
  mode_t             mode_q;
  logic [LEN_W-1:0]  len_q, len_wr;
  logic [DIV_W-1:0]  period_q;
  logic [NFLAGS-1:0] flags_q, irqen_q, set_vec;
  logic              hit_run, hit_mode, hit_len, hit_per, hit_flags, hit_irq;

  assign hit_run   = wr_en_i && (wr_addr_i == A_RUN);
  assign hit_mode  = wr_en_i && (wr_addr_i == A_MODE);
  assign hit_len   = wr_en_i && (wr_addr_i == A_LEN);
  assign hit_per   = wr_en_i && (wr_addr_i == A_PERIOD);
  assign hit_flags = wr_en_i && (wr_addr_i == A_FLAGS);
  assign hit_irq   = wr_en_i && (wr_addr_i == A_IRQEN);

  // a start is also taken when a single pass ends on the same edge
  assign start_o = hit_run && wr_data_i[0] && (!en_q || stop_i);

  // out-of-range lengths are clamped into 1..PAT_W
  always_comb begin
    len_wr = wr_data_i[LEN_W-1:0];
    if (len_wr == '0)                   len_wr = LEN_W'(1);
    else if (len_wr > LEN_W'(PAT_W))    len_wr = LEN_W'(PAT_W);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      mode_q   <= '0;
      len_q    <= LEN_W'(PAT_W / 2);
      period_q <= '0;
      irqen_q  <= '0;
    end else begin
      if (hit_run)          en_q <= wr_data_i[0];
      else if (stop_i)      en_q <= 1'b0;
      if (hit_mode && !en_q) mode_q <= mode_t'(wr_data_i[1:0]);
      if (hit_len && !en_q)  len_q  <= len_wr;
      if (hit_per)           period_q <= wr_data_i[DIV_W-1:0];
      if (hit_irq)           irqen_q  <= wr_data_i[NFLAGS-1:0];
    end
  end

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        data_o[g*DATA_W +: DATA_W] <= '0;
      else if (wr_en_i && (wr_addr_i == 3'(int'(A_DATA0) + g)))
        data_o[g*DATA_W +: DATA_W] <= wr_data_i;
    end
  end

  assign set_vec[FLAG_FILL] = fill_set_i;
  assign set_vec[FLAG_DONE] = done_set_i;

  // a set event wins over a clear in the same cycle
  for (genvar f = 0; f < NFLAGS; f++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        flags_q[f] <= 1'b0;
      else if (set_vec[f])                flags_q[f] <= 1'b1;
      else if (hit_flags && wr_data_i[f]) flags_q[f] <= 1'b0;
    end
  end

  assign en_o     = en_q;
  assign mode_o   = mode_q;
  assign len_o    = len_q;
  assign period_o = period_q;
  assign flags_o  = flags_q;
  assign irq_o    = |(flags_q & irqen_q);

  // R9: mode and length are frozen while running
  assert_mode_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> (mode_q == $past(mode_q) && len_q == $past(len_q)));
  // R10: a clear with no coincident set drops the done flag
  assert_done_w1c_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_flags && wr_data_i[FLAG_DONE] && !done_set_i) |=> !flags_q[FLAG_DONE]);
  // R11: a run-bit write of 0 stops the block
  assert_stop_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_run && !wr_data_i[0]) |=> !en_q);
endmodule

// File: rtl/spg_engine.sv
module spg_engine
  import spg_pkg::*;
#(
  parameter int PAT_W = 64,
  parameter int LEN_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             tick_i,
  input  mode_t            mode_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [PAT_W-1:0] data_i,
  output logic             pat_o,
  output logic             fill_set_o,
  output logic             done_set_o,
  output logic             stop_o
);
  localparam int IDX_W = $clog2(PAT_W);

  logic [PAT_W-1:0] sh_q;
  logic [LEN_W-1:0] idx_q, len_m1;
  logic [IDX_W-1:0] top_idx;
  logic             last, step, wrap;

  assign len_m1  = len_i - 1'b1;
  assign top_idx = len_m1[IDX_W-1:0];
  assign last    = (idx_q == len_m1);
  assign step    = en_i && tick_i;
  assign wrap    = step && last;

  assign done_set_o = wrap;
  assign fill_set_o = start_i || (wrap && mode_i.rpt);
  assign stop_o     = wrap && !mode_i.rpt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (start_i || (wrap && mode_i.rpt)) begin
      sh_q  <= data_i;
      idx_q <= '0;
    end else if (wrap) begin
      idx_q <= '0;
    end else if (step) begin
      sh_q  <= mode_i.left ? (sh_q << 1) : (sh_q >> 1);
      idx_q <= idx_q + 1'b1;
    end
  end

  assign pat_o = en_i && (mode_i.left ? sh_q[top_idx] : sh_q[0]);

  // R3: the bit position never runs past the pass length
  assert_idx_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (idx_q < len_i));
  // R6: the last tick of a single pass clears the run bit
  assert_once_stops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && !mode_i.rpt && !start_i) |=> !en_i);
  // R7: a looping pass restarts at bit position 0
  assert_loop_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && mode_i.rpt) |=> (idx_q == '0));
endmodule

// File: rtl/shift_pattern_gen.sv
module shift_pattern_gen
  import spg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              pat_o,
  output logic              run_o,
  output logic [NFLAGS-1:0] flags_o,
  output logic              irq_o
);
  localparam int PAT_W = 2 * DATA_W;
  localparam int LEN_W = $clog2(PAT_W) + 1;

  logic             en, start, tick, fill_set, done_set, stop;
  mode_t            mode;
  logic [LEN_W-1:0] len;
  logic [DIV_W-1:0] period;
  logic [PAT_W-1:0] data;

  spg_regs #(.DATA_W(DATA_W), .PAT_W(PAT_W), .DIV_W(DIV_W), .LEN_W(LEN_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .fill_set_i(fill_set), .done_set_i(done_set), .stop_i(stop),
    .en_o(en), .start_o(start), .mode_o(mode), .len_o(len),
    .period_o(period), .data_o(data), .flags_o(flags_o), .irq_o(irq_o)
  );

  spg_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .en_i(en), .start_i(start), .period_i(period), .tick_o(tick)
  );

  spg_engine #(.PAT_W(PAT_W), .LEN_W(LEN_W)) u_engine (
    .clk_i, .rst_ni, .en_i(en), .start_i(start), .tick_i(tick), .mode_i(mode),
    .len_i(len), .data_i(data), .pat_o(pat_o),
    .fill_set_o(fill_set), .done_set_o(done_set), .stop_o(stop)
  );

  assign run_o = en;
endmodule

// File: tb/shift_pattern_gen_bench.sv
module shift_pattern_gen_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        pat_o, run_o, irq_o;
  logic [1:0]  flags_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  shift_pattern_gen u_shift_pattern_gen (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the sampling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic check_pass(input logic [63:0] p, input int len, input bit left,
                            input int per, input string req);
    int bad = 0;
    for (int k = 0; k < len; k++) begin
      for (int j = 0; j <= per; j++) begin
        logic e;
        e = left ? p[len-1-k] : p[k];
        if (pat_o !== e) bad++;
        @(negedge clk_i);
      end
    end
    check(bad == 0, req, "bad pattern samples", bad, 0);
  endtask

  task automatic t_reset;
    check(pat_o === 1'b0, "R1", "pat_o", pat_o, 0);
    check(run_o === 1'b0, "R1", "run_o", run_o, 0);
    check(flags_o === 2'b00, "R1", "flags_o", flags_o, 0);
    check(irq_o === 1'b0, "R1", "irq_o", irq_o, 0);
  endtask

  task automatic t_right_once;
    wr(3'd1, 32'd0); wr(3'd2, 32'd24); wr(3'd3, 32'd2);
    wr(3'd4, 32'h00A5_C3F1); wr(3'd5, 32'h0); wr(3'd6, 32'h3);
    wr(3'd0, 32'd1);
    check(run_o === 1'b1, "R2", "run_o after start", run_o, 1);
    check(flags_o[0] === 1'b1, "R8", "fill at start", flags_o, 1);
    check_pass(64'h00A5_C3F1, 24, 1'b0, 2, "R3 R4");
    check(run_o === 1'b0, "R6", "run_o after pass", run_o, 0);
    check(pat_o === 1'b0, "R6", "pat_o after pass", pat_o, 0);
    check(flags_o === 2'b11, "R6", "flags after pass", flags_o, 3);
  endtask

  task automatic t_left_once;
    wr(3'd1, 32'd2); wr(3'd2, 32'd60); wr(3'd3, 32'd0);
    wr(3'd4, 32'h1357_9BDF); wr(3'd5, 32'h0ABC_DEF1); wr(3'd6, 32'h3);
    wr(3'd0, 32'd1);
    check_pass(64'h0ABC_DEF1_1357_9BDF, 60, 1'b1, 0, "R5");
    check(run_o === 1'b0, "R6", "run_o after left pass", run_o, 0);
  endtask

  task automatic t_repeat;
    wr(3'd1, 32'd1); wr(3'd2, 32'd8); wr(3'd3, 32'd1);
    wr(3'd4, 32'h5B); wr(3'd5, 32'h0); wr(3'd6, 32'h3);
    wr(3'd0, 32'd1);                       // edge E
    check(pat_o === 1'b1, "R4", "first bit of looping pass", pat_o, 1);
    wr(3'd4, 32'h3C);                      // E+1: new data for next pass
    wr(3'd6, 32'h3);                       // E+2: clear start fill
    check(flags_o === 2'b00, "R10", "flags after clear", flags_o, 0);
    repeat (14) @(negedge clk_i);          // E+16: boundary
    check(flags_o === 2'b11, "R7 R8", "flags at boundary", flags_o, 3);
    check(run_o === 1'b1, "R7", "run_o at boundary", run_o, 1);
    check_pass(64'h3C, 8, 1'b0, 1, "R7");  // ends at E+32
    wr(3'd1, 32'd0);                       // E+33: refused mode write
    repeat (16) @(negedge clk_i);          // E+49
    check(run_o === 1'b1, "R9", "run_o after refused mode write", run_o, 1);
    wr(3'd0, 32'd0);
    check(run_o === 1'b0, "R11", "run_o after stop", run_o, 0);
    check(pat_o === 1'b0, "R11", "pat_o after stop", pat_o, 0);
    repeat (4) @(negedge clk_i);
    check(pat_o === 1'b0, "R11", "pat_o stays low", pat_o, 0);
  endtask

  task automatic t_irq;
    check(flags_o === 2'b11, "R10", "flags before irq test", flags_o, 3);
    check(irq_o === 1'b0, "R10", "irq with no enables", irq_o, 0);
    wr(3'd7, 32'h2);
    check(irq_o === 1'b1, "R10", "irq done enabled", irq_o, 1);
    wr(3'd6, 32'h2);
    check(flags_o === 2'b01, "R10", "done cleared only", flags_o, 1);
    check(irq_o === 1'b0, "R10", "irq fill masked", irq_o, 0);
    wr(3'd7, 32'h1);
    check(irq_o === 1'b1, "R10", "irq fill enabled", irq_o, 1);
    wr(3'd6, 32'h1);
    check(irq_o === 1'b0, "R10", "irq after fill clear", irq_o, 0);
    check(flags_o === 2'b00, "R10", "flags all clear", flags_o, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_right_once();
    t_left_once();
    t_repeat();
    t_irq();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule